// File: doc/BRIEF.md
# Stack Control-Transfer Sequencer

This block carries out the multi-cycle stack sequences an 8-bit processor uses to change control flow. It handles six of them: software break, subroutine call, subroutine return, status push, status pull and accumulator pull. The stack occupies page 1 of a 16-bit address space. Its addresses are the page number followed by an 8-bit stack pointer. The sequencer drives a single memory port with at most one access per clock. It reproduces every dummy access exactly, so a bus trace taken from it matches a cycle-accurate model.

A command arrives on a valid/ready channel. It carries the operation code and the register values the sequence starts from: program counter, stack pointer, status byte and accumulator. A command is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the accepting edge until the result has been taken.

The result leaves on a second valid/ready channel. It carries the updated registers and the total cycle count of the instruction, with the opcode fetch counted. While `res_valid` is high and `res_ready` is low, the result holds steady, no new command is accepted and the memory port stays idle. The memory returns read data combinationally in the same cycle as the address, and the sequencer captures it at the clock edge that ends that cycle.

Top module: `stk_seq`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_ready` is 1, `res_valid` is 0 and `mem_en` is 0.
- R2: Every stack access uses address 0x0100 + S. A push writes at S and then decrements S. A pull first increments S and then reads at the new S. S wraps within 8 bits.
- R3: Break (code 0) takes these accesses in order:
  - a dummy read at PC, after which PC is incremented;
  - three pushes: PC high byte, PC low byte, then the status byte with bits 4 and 5 set;
  - reads at 0xFFFE (new PC low byte) and 0xFFFF (new PC high byte).
  The result status is the input status with bit 2 (interrupt disable) set.
- R4: Call (code 1) takes these accesses in order:
  - a read of the target low byte at PC, after which PC is incremented;
  - a dummy read at the current stack address;
  - pushes of PC high byte, then PC low byte;
  - a read of the target high byte at PC.
  The result PC is the target.
- R5: Return (code 2) takes these accesses in order:
  - dummy reads at PC and at the current stack address;
  - pulls of the PC low byte, then the PC high byte;
  - a dummy read at the pulled PC.
  The result PC is the pulled PC plus 1.
- R6: Status push (code 3) does a dummy read at PC, then pushes the status byte with bits 4 and 5 set.
- R7: Status pull (code 4) does dummy reads at PC and at the stack address, then pulls a byte. The result status is that byte with bit 4 cleared and bit 5 set.
- R8: Accumulator pull (code 5) follows the same access pattern as R7 and loads the pulled byte into the accumulator. Status bit 7 (N) takes the value's bit 7, and bit 1 (Z) is set exactly when the value is zero. All other status bits are unchanged.
- R9: Accesses fall in consecutive cycles. `res_cycles` equals the number of accesses plus 1: break 7, call 6, return 6, status or accumulator pull 4, status push 3.
- R10: While `res_valid` is high and `res_ready` is low, every result field holds its value, `mem_en` is 0 and `cmd_ready` is 0.
- R11: After a command is accepted, `cmd_ready` stays 0 until the result has been taken.
- R12: Codes 6 and 7 make no memory access. They return the input registers unchanged with `res_cycles` equal to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_op | input | 3 | Operation code (see R3 to R8 and R12) |
| cmd_pc | input | 16 | Starting program counter |
| cmd_sp | input | 8 | Starting stack pointer |
| cmd_status | input | 8 | Starting status byte |
| cmd_acc | input | 8 | Starting accumulator |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_pc | output | 16 | Final program counter |
| res_sp | output | 8 | Final stack pointer |
| res_status | output | 8 | Final status byte |
| res_acc | output | 8 | Final accumulator |
| res_cycles | output | 4 | Total bus cycles of the instruction |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the current address |

## Verification
Two functions can coincide in one cycle. A finished result can sit stalled on its output while the next command is already offered on the input. The bench provokes this by holding `res_ready` low for several cycles with `cmd_valid` raised for a different operation. In each of those cycles it checks that `cmd_ready` and `mem_en` stay low and that every result field keeps its value. A second coincidence is the stack-pointer increment landing in the same cycle as the read it addresses. Pull and return runs sweep all 256 stack-pointer values, including the wrap from 0xFF to 0x00. For each run, the bench compares the traced read address and the pulled value with figures computed from the start values.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // status bit positions
  localparam int FLAG_N = 7;
  localparam int FLAG_U = 5;
  localparam int FLAG_B = 4;
  localparam int FLAG_I = 2;
  localparam int FLAG_Z = 1;

  typedef enum logic [2:0] {
    OP_BREAK  = 3'd0,
    OP_CALL   = 3'd1,
    OP_RETURN = 3'd2,
    OP_PUSH_P = 3'd3,
    OP_PULL_P = 3'd4,
    OP_PULL_A = 3'd5
  } stk_op_e;

  typedef enum logic [1:0] {
    AS_PC,
    AS_STACK,
    AS_VEC_LO,
    AS_VEC_HI
  } addr_sel_e;

  typedef enum logic [1:0] {
    WS_PCH,
    WS_PCL,
    WS_STATUS
  } wdat_sel_e;

  typedef enum logic [2:0] {
    DST_NONE,
    DST_TMP,
    DST_PCL,
    DST_PCH,
    DST_JOIN,
    DST_STATUS,
    DST_ACC
  } dst_e;

  typedef struct packed {
    logic      access;
    logic      we;
    addr_sel_e asel;
    wdat_sel_e wsel;
    logic      sp_pre_inc;
    logic      sp_post_dec;
    logic      pc_inc;
    logic      set_i;
    dst_e      dst;
  } stk_uop_t;

  function automatic stk_uop_t mk_uop(
      input logic access, input logic we, input addr_sel_e asel,
      input wdat_sel_e wsel, input logic pre, input logic dec,
      input logic pcinc, input logic seti, input dst_e dst);
    stk_uop_t u;
    u.access      = access;
    u.we          = we;
    u.asel        = asel;
    u.wsel        = wsel;
    u.sp_pre_inc  = pre;
    u.sp_post_dec = dec;
    u.pc_inc      = pcinc;
    u.set_i       = seti;
    u.dst         = dst;
    return u;
  endfunction

endpackage

// File: rtl/stk_uop_decode.sv
module stk_uop_decode
  import stk_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  stk_op_e             op,
  input  logic [STEP_W-1:0]   step,
  output stk_uop_t            uop,
  output logic                last
);

  // shorthand micro-ops
  localparam stk_uop_t U_IDLE  = mk_uop(1'b0, 1'b0, AS_PC,    WS_PCH,    1'b0, 1'b0, 1'b0, 1'b0, DST_NONE);
  localparam stk_uop_t U_RDPC  = mk_uop(1'b1, 1'b0, AS_PC,    WS_PCH,    1'b0, 1'b0, 1'b0, 1'b0, DST_NONE);
  localparam stk_uop_t U_RDSTK = mk_uop(1'b1, 1'b0, AS_STACK, WS_PCH,    1'b0, 1'b0, 1'b0, 1'b0, DST_NONE);

  always_comb begin
    uop  = U_IDLE;
    last = 1'b0;
    case (op)
      OP_BREAK: begin
        case (int'(step))
          0: uop = mk_uop(1'b1, 1'b0, AS_PC, WS_PCH, 1'b0, 1'b0, 1'b1, 1'b0, DST_NONE);
          1: uop = mk_uop(1'b1, 1'b1, AS_STACK, WS_PCH, 1'b0, 1'b1, 1'b0, 1'b0, DST_NONE);
          2: uop = mk_uop(1'b1, 1'b1, AS_STACK, WS_PCL, 1'b0, 1'b1, 1'b0, 1'b0, DST_NONE);
          3: uop = mk_uop(1'b1, 1'b1, AS_STACK, WS_STATUS, 1'b0, 1'b1, 1'b0, 1'b1, DST_NONE);
          4: uop = mk_uop(1'b1, 1'b0, AS_VEC_LO, WS_PCH, 1'b0, 1'b0, 1'b0, 1'b0, DST_PCL);
          default: begin
            uop  = mk_uop(1'b1, 1'b0, AS_VEC_HI, WS_PCH, 1'b0, 1'b0, 1'b0, 1'b0, DST_PCH);
            last = 1'b1;
          end
        endcase
      end
      OP_CALL: begin
        case (int'(step))
          0: uop = mk_uop(1'b1, 1'b0, AS_PC, WS_PCH, 1'b0, 1'b0, 1'b1, 1'b0, DST_TMP);
          1: uop = U_RDSTK;
          2: uop = mk_uop(1'b1, 1'b1, AS_STACK, WS_PCH, 1'b0, 1'b1, 1'b0, 1'b0, DST_NONE);
          3: uop = mk_uop(1'b1, 1'b1, AS_STACK, WS_PCL, 1'b0, 1'b1, 1'b0, 1'b0, DST_NONE);
          default: begin
            uop  = mk_uop(1'b1, 1'b0, AS_PC, WS_PCH, 1'b0, 1'b0, 1'b0, 1'b0, DST_JOIN);
            last = 1'b1;
          end
        endcase
      end
      OP_RETURN: begin
        case (int'(step))
          0: uop = U_RDPC;
          1: uop = U_RDSTK;
          2: uop = mk_uop(1'b1, 1'b0, AS_STACK, WS_PCH, 1'b1, 1'b0, 1'b0, 1'b0, DST_PCL);
          3: uop = mk_uop(1'b1, 1'b0, AS_STACK, WS_PCH, 1'b1, 1'b0, 1'b0, 1'b0, DST_PCH);
          default: begin
            uop  = mk_uop(1'b1, 1'b0, AS_PC, WS_PCH, 1'b0, 1'b0, 1'b1, 1'b0, DST_NONE);
            last = 1'b1;
          end
        endcase
      end
      OP_PUSH_P: begin
        if (int'(step) == 0) begin
          uop = U_RDPC;
        end else begin
          uop  = mk_uop(1'b1, 1'b1, AS_STACK, WS_STATUS, 1'b0, 1'b1, 1'b0, 1'b0, DST_NONE);
          last = 1'b1;
        end
      end
      OP_PULL_P, OP_PULL_A: begin
        case (int'(step))
          0: uop = U_RDPC;
          1: uop = U_RDSTK;
          default: begin
            uop  = mk_uop(1'b1, 1'b0, AS_STACK, WS_PCH, 1'b1, 1'b0, 1'b0, 1'b0,
                          (op == OP_PULL_P) ? DST_STATUS : DST_ACC);
            last = 1'b1;
          end
        endcase
      end
      default: begin
        uop  = U_IDLE;
        last = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/stk_step_ctrl.sv
module stk_step_ctrl
  import stk_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              res_ready,
  input  logic              last,
  output logic              cmd_ready,
  output logic              res_valid,
  output logic              load,
  output logic              busy,
  output stk_op_e           op_q,
  output logic [STEP_W-1:0] step
);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} st_e;
  st_e state;

  assign cmd_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_DONE);
  assign busy      = (state == ST_BUSY);
  assign load      = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
      op_q  <= OP_BREAK;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          state <= ST_BUSY;
          step  <= '0;
          op_q  <= stk_op_e'(cmd_op);
        end
        ST_BUSY: begin
          if (last) state <= ST_DONE;
          else      step  <= step + 1'b1;
        end
        default: if (res_ready) state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          CYC_W      = 4,
  parameter int          FETCH_CYC  = 1,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
  localparam int         ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              busy,
  input  stk_uop_t          uop,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic [DATA_W-1:0] cmd_sp,
  input  logic [DATA_W-1:0] cmd_status,
  input  logic [DATA_W-1:0] cmd_acc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] acc,
  output logic [CYC_W-1:0]  cycles
);

  logic [DATA_W-1:0] tmp;
  logic [DATA_W-1:0] sp_eff;
  logic [DATA_W-1:0] pushed_status;

  assign sp_eff        = uop.sp_pre_inc ? sp + 1'b1 : sp;
  assign pushed_status = status | DATA_W'(1 << FLAG_B) | DATA_W'(1 << FLAG_U);
  assign mem_en        = busy && uop.access;
  assign mem_we        = mem_en && uop.we;

  always_comb begin
    case (uop.asel)
      AS_STACK:  mem_addr = {STACK_PAGE, sp_eff};
      AS_VEC_LO: mem_addr = IRQ_VEC;
      AS_VEC_HI: mem_addr = IRQ_VEC + 16'd1;
      default:   mem_addr = pc;
    endcase
    case (uop.wsel)
      WS_PCH:    mem_wdata = pc[ADDR_W-1:DATA_W];
      WS_PCL:    mem_wdata = pc[DATA_W-1:0];
      default:   mem_wdata = pushed_status;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      sp     <= '0;
      status <= '0;
      acc    <= '0;
      tmp    <= '0;
      cycles <= '0;
    end else if (load) begin
      pc     <= cmd_pc;
      sp     <= cmd_sp;
      status <= cmd_status;
      acc    <= cmd_acc;
      cycles <= CYC_W'(FETCH_CYC);
    end else if (busy) begin
      if (uop.pc_inc) pc <= pc + 1'b1;
      if (uop.sp_pre_inc)       sp <= sp + 1'b1;
      else if (uop.sp_post_dec) sp <= sp - 1'b1;
      if (uop.set_i) status[FLAG_I] <= 1'b1;
      if (uop.access) begin
        cycles <= cycles + 1'b1;
        case (uop.dst)
          DST_TMP:  tmp <= mem_rdata;
          DST_PCL:  pc[DATA_W-1:0] <= mem_rdata;
          DST_PCH:  pc[ADDR_W-1:DATA_W] <= mem_rdata;
          DST_JOIN: pc <= {mem_rdata, tmp};
          DST_STATUS: begin
            status         <= mem_rdata;
            status[FLAG_B] <= 1'b0;
            status[FLAG_U] <= 1'b1;
          end
          DST_ACC: begin
            acc            <= mem_rdata;
            status[FLAG_N] <= mem_rdata[DATA_W-1];
            status[FLAG_Z] <= (mem_rdata == '0);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          STEP_W     = 3,
  parameter int          CYC_W      = 4,
  parameter int          FETCH_CYC  = 1,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
  localparam int         ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic [DATA_W-1:0] cmd_sp,
  input  logic [DATA_W-1:0] cmd_status,
  input  logic [DATA_W-1:0] cmd_acc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_pc,
  output logic [DATA_W-1:0] res_sp,
  output logic [DATA_W-1:0] res_status,
  output logic [DATA_W-1:0] res_acc,
  output logic [CYC_W-1:0]  res_cycles,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  stk_op_e           op_q;
  logic [STEP_W-1:0] step;
  stk_uop_t          uop;
  logic              last;
  logic              load;
  logic              busy;

  stk_step_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .res_ready (res_ready),
    .last      (last),
    .cmd_ready (cmd_ready),
    .res_valid (res_valid),
    .load      (load),
    .busy      (busy),
    .op_q      (op_q),
    .step      (step)
  );

  stk_uop_decode #(.STEP_W(STEP_W)) u_dec (
    .op   (op_q),
    .step (step),
    .uop  (uop),
    .last (last)
  );

  stk_datapath #(
    .DATA_W     (DATA_W),
    .CYC_W      (CYC_W),
    .FETCH_CYC  (FETCH_CYC),
    .STACK_PAGE (STACK_PAGE),
    .IRQ_VEC    (IRQ_VEC)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .busy       (busy),
    .uop        (uop),
    .cmd_pc     (cmd_pc),
    .cmd_sp     (cmd_sp),
    .cmd_status (cmd_status),
    .cmd_acc    (cmd_acc),
    .mem_rdata  (mem_rdata),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pc         (res_pc),
    .sp         (res_sp),
    .status     (res_status),
    .acc        (res_acc),
    .cycles     (res_cycles)
  );

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int         ADDR_W     = 16,
  parameter int         DATA_W     = 8,
  parameter int         CYC_W      = 4,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] res_pc,
  input logic [DATA_W-1:0] res_sp,
  input logic [DATA_W-1:0] res_status,
  input logic [DATA_W-1:0] res_acc,
  input logic [CYC_W-1:0]  res_cycles
);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pc) && $stable(res_sp)
      && $stable(res_status) && $stable(res_acc) && $stable(res_cycles));

  assert_quiet_while_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_en && !cmd_ready);

  assert_write_in_stack_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we |-> mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  assert_push_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && $past(mem_en && mem_we)
      |-> mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) - 1'b1);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

endmodule

bind stk_seq stk_seq_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .CYC_W      (CYC_W),
  .STACK_PAGE (STACK_PAGE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .res_pc     (res_pc),
  .res_sp     (res_sp),
  .res_status (res_status),
  .res_acc    (res_acc),
  .res_cycles (res_cycles)
);

// File: tb/stk_seq_tb.sv
module stk_seq_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_pc;
  logic [7:0]  cmd_sp, cmd_status, cmd_acc;
  logic        res_valid, res_ready;
  logic [15:0] res_pc;
  logic [7:0]  res_sp, res_status, res_acc;
  logic [3:0]  res_cycles;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  stk_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_pc(cmd_pc), .cmd_sp(cmd_sp), .cmd_status(cmd_status), .cmd_acc(cmd_acc),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_pc(res_pc), .res_sp(res_sp), .res_status(res_status), .res_acc(res_acc),
    .res_cycles(res_cycles),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  bit done = 0;

  logic [7:0]  stk [0:255];
  int          tcnt;
  logic [15:0] t_addr [0:7];
  logic        t_we   [0:7];
  logic [7:0]  t_wd   [0:7];

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : fmem(mem_addr);

  always @(posedge clk)
    if (mem_en && mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  always @(negedge clk)
    if (rst_n && mem_en) begin
      if (tcnt < 8) begin
        t_addr[tcnt] = mem_addr;
        t_we[tcnt]   = mem_we;
        t_wd[tcnt]   = mem_wdata;
      end
      tcnt = tcnt + 1;
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected finish", cyc_cnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [2:0] op, input logic [7:0] s, input int hold);
    logic [7:0]  seed, p, a, v, lo, hi, s1, s2;
    logic [15:0] pc, pcn, vec;
    logic [15:0] e_addr [0:7];
    logic        e_we   [0:7];
    logic [7:0]  e_wd   [0:7];
    int          e_n;
    logic [15:0] x_pc;
    logic [7:0]  x_sp, x_p, x_a;
    logic [15:0] h_pc;
    logic [7:0]  h_sp, h_p, h_a;
    logic [3:0]  h_c;
    string       tg;
    int          w;

    seed = 8'h96 ^ (8'(op) * 8'h11);
    pc   = (s == 8'h40) ? 16'hFFFF : {~s | 8'h80, s ^ 8'h3C};
    p    = s ^ 8'hA6;
    a    = ~s;
    for (int i = 0; i < 256; i++) stk[i] = 8'(i) ^ seed;
    s1   = s + 8'd1;
    s2   = s + 8'd2;
    pcn  = pc + 16'd1;
    vec  = {fmem(16'hFFFF), fmem(16'hFFFE)};
    for (int i = 0; i < 8; i++) begin e_addr[i] = '0; e_we[i] = 1'b0; e_wd[i] = '0; end
    x_pc = pc; x_sp = s; x_p = p; x_a = a; e_n = 0;
    case (op)
      3'd0: begin  // R3
        tg = "R3";
        e_addr[0] = pc;
        e_addr[1] = {8'h01, s};          e_we[1] = 1; e_wd[1] = pcn[15:8];
        e_addr[2] = {8'h01, s - 8'd1};   e_we[2] = 1; e_wd[2] = pcn[7:0];
        e_addr[3] = {8'h01, s - 8'd2};   e_we[3] = 1; e_wd[3] = p | 8'h30;
        e_addr[4] = 16'hFFFE;
        e_addr[5] = 16'hFFFF;
        e_n = 6; x_pc = vec; x_sp = s - 8'd3; x_p = p | 8'h04;
      end
      3'd1: begin  // R4
        tg = "R4";
        lo = fmem(pc); hi = fmem(pcn);
        e_addr[0] = pc;
        e_addr[1] = {8'h01, s};
        e_addr[2] = {8'h01, s};          e_we[2] = 1; e_wd[2] = pcn[15:8];
        e_addr[3] = {8'h01, s - 8'd1};   e_we[3] = 1; e_wd[3] = pcn[7:0];
        e_addr[4] = pcn;
        e_n = 5; x_pc = {hi, lo}; x_sp = s - 8'd2;
      end
      3'd2: begin  // R5
        tg = "R5";
        lo = s1 ^ seed; hi = s2 ^ seed;
        e_addr[0] = pc;
        e_addr[1] = {8'h01, s};
        e_addr[2] = {8'h01, s1};
        e_addr[3] = {8'h01, s2};
        e_addr[4] = {hi, lo};
        e_n = 5; x_pc = {hi, lo} + 16'd1; x_sp = s2;
      end
      3'd3: begin  // R6
        tg = "R6";
        e_addr[0] = pc;
        e_addr[1] = {8'h01, s};          e_we[1] = 1; e_wd[1] = p | 8'h30;
        e_n = 2; x_sp = s - 8'd1;
      end
      3'd4, 3'd5: begin  // R7 / R8
        tg = (op == 3'd4) ? "R7" : "R8";
        v = s1 ^ seed;
        e_addr[0] = pc;
        e_addr[1] = {8'h01, s};
        e_addr[2] = {8'h01, s1};
        e_n = 3; x_sp = s1;
        if (op == 3'd4) x_p = (v & 8'hCF) | 8'h20;
        else begin
          x_a = v;
          x_p = (p & 8'h7D) | (v & 8'h80) | ((v == 8'h00) ? 8'h02 : 8'h00);
        end
      end
      default: tg = "R12";
    endcase

    @(posedge clk); #1;
    tcnt = 0;
    cmd_op = op; cmd_pc = pc; cmd_sp = s; cmd_status = p; cmd_acc = a;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R11 ready low while busy", 32'(cmd_ready), 0);
    w = 0;
    while (!res_valid && w < 20) begin @(negedge clk); w++; end
    chk(res_valid == 1'b1, {tg, " completion"}, 32'(res_valid), 1);

    h_pc = res_pc; h_sp = res_sp; h_p = res_status; h_a = res_acc; h_c = res_cycles;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = op ^ 3'd1;
      @(negedge clk);
      chk(!cmd_ready && !mem_en && res_valid, "R10 stall quiet",
          {29'd0, cmd_ready, mem_en, res_valid}, 32'd1);
      chk(res_pc == h_pc && res_sp == h_sp && res_status == h_p && res_acc == h_a
          && res_cycles == h_c, "R10 stall stable", {res_pc, res_sp, res_status}, {h_pc, h_sp, h_p});
    end

    chk(tcnt == e_n, {tg, " R9 access count"}, 32'(tcnt), 32'(e_n));
    for (int i = 0; i < e_n && i < 8; i++) begin
      chk(t_addr[i] == e_addr[i], {tg, " R2 address"}, 32'(t_addr[i]), 32'(e_addr[i]));
      chk(t_we[i] == e_we[i], {tg, " direction"}, 32'(t_we[i]), 32'(e_we[i]));
      if (e_we[i]) chk(t_wd[i] == e_wd[i], {tg, " write data"}, 32'(t_wd[i]), 32'(e_wd[i]));
    end
    chk(res_pc == x_pc, {tg, " pc"}, 32'(res_pc), 32'(x_pc));
    chk(res_sp == x_sp, {tg, " R2 sp"}, 32'(res_sp), 32'(x_sp));
    chk(res_status == x_p, {tg, " status"}, 32'(res_status), 32'(x_p));
    chk(res_acc == x_a, {tg, " acc"}, 32'(res_acc), 32'(x_a));
    chk(32'(res_cycles) == e_n + 1, {tg, " R9 cycles"}, 32'(res_cycles), 32'(e_n + 1));

    @(posedge clk); #1;
    cmd_valid = 1'b0; res_ready = 1'b1;
    @(posedge clk); #1;
    res_ready = 1'b0;
    @(negedge clk);
    chk(cmd_ready && !res_valid, "R11 ready after take", {30'd0, cmd_ready, res_valid}, 32'd2);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; res_ready = 1'b0;
    cmd_op = '0; cmd_pc = '0; cmd_sp = '0; cmd_status = '0; cmd_acc = '0;
    tcnt = 0;
    for (int i = 0; i < 256; i++) stk[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready && !res_valid && !mem_en, "R1 in reset",
        {29'd0, cmd_ready, res_valid, mem_en}, 32'd4);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !res_valid && !mem_en, "R1 after reset",
        {29'd0, cmd_ready, res_valid, mem_en}, 32'd4);

    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 256; s++)
        run(3'(op), 8'(s), (s % 4 == 3) ? 3 : 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule